// File: doc/BRIEF.md
# Video Port Access Pacer with Interrupt Gating

This block sits on the I/O path between a fast CPU and a slow video controller. The controller needs its video-memory data port accesses spaced apart by a minimum time. The block counts clock cycles from each data-port access. If the CPU asks for another data-port access before the programmed interval has passed, the block holds the CPU with a wait signal. It lets the access through once the interval is over, so no access is dropped. The interval is given in clock cycles on an input, so one design serves every bus clock rate. For example, 8 µs is 29 cycles at 3.58 MHz and 115 cycles at 14.3 MHz.

The block also stands between the controller's interrupt line and the CPU. The interrupt stays masked until software writes a boot-complete flag. After that, the interrupt is held back while an access sequence to the controller is open. It reaches the CPU as soon as the sequence closes, provided the controller still asserts it.

Top module: `io_pacer`

## Requirements
- R1: A data-port request (io_port = 0) made when no data strobe has happened within the programmed interval completes in the same cycle: dev_data_stb is 1 and cpu_wait is 0. This includes the first request after reset.
- R2: Two consecutive dev_data_stb pulses are at least cfg_interval cycles apart. A cfg_interval of 0 or 1 allows strobes on back-to-back cycles.
- R3: A data-port request made too early raises cpu_wait in the same cycle, with no strobe. The request is held and not dropped: while io_req stays high, the strobe comes exactly cfg_interval cycles after the previous one.
- R4: Requests to any port other than the data port never raise cpu_wait. A control-port request (io_port = 1) gives dev_ctrl_stb in the same cycle.
- R5: The boot flag is cleared by reset. A write to port 2 with io_wbit = 1 sets it, and a write with io_wbit = 0 clears it. The new value takes effect from the next cycle. While the flag is clear, cpu_irq stays 0.
- R6: A control-port write opens an access sequence, and cpu_irq is 0 from the next cycle. The sequence closes in the first cycle that meets all three conditions: at least one data strobe has happened since the control write, the interval has run out, and there is no strobe. Without a data strobe, the sequence stays open.
- R7: A deferred interrupt is delivered in the cycle after the sequence closes. With interval N, that is N cycles after the edge that took the last data strobe, as long as vid_irq is still high.
- R8: cpu_irq is 1 only when vid_irq is 1.
- R9: Port 3 is an unrelated port. A request to it does not stall, does not open a sequence and does not change the boot flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_interval | input | CNT_W | Minimum data-port spacing, in clock cycles |
| io_req | input | 1 | CPU I/O request; held high until the request completes |
| io_port | input | 2 | Port select: 0 data, 1 control, 2 boot flag, 3 other |
| io_write | input | 1 | 1 for a write, 0 for a read |
| io_wbit | input | 1 | Write data bit used by the boot-flag port |
| cpu_wait | output | 1 | Stalls the CPU's current request |
| dev_data_stb | output | 1 | Data-port access strobe to the video controller |
| dev_ctrl_stb | output | 1 | Control-port access strobe to the video controller |
| vid_irq | input | 1 | Interrupt request from the video controller (level) |
| cpu_irq | output | 1 | Gated interrupt request to the CPU |

## Verification
The assertions assume that the CPU keeps io_req, io_port and io_write steady while cpu_wait is high. They also assume that cfg_interval does not change during a burst, because the spacing check compares each gap with the interval currently on the input. The bench changes cfg_interval only while the block is idle with no request, and it holds every request until the cycle in which it completes. The interrupt checks assume vid_irq is a level signal. The bench holds vid_irq high throughout each interrupt scenario, so the exact delivery cycle can be observed.

// File: rtl/io_pacer_pkg.sv
package io_pacer_pkg;
   typedef enum logic [1:0] {
      PORT_DATA  = 2'd0,
      PORT_CTRL  = 2'd1,
      PORT_BOOT  = 2'd2,
      PORT_OTHER = 2'd3
   } port_sel_e;
endpackage

// File: rtl/pacer_interval.sv
// Spacing counter: loads interval-1 on each data strobe, counts down to zero.
module pacer_interval #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_interval,
   input  logic             data_go,
   output logic             spacing_done
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] reload;

   assign reload       = (cfg_interval > ONE) ? cfg_interval - ONE : ZERO;
   assign spacing_done = (remain_q == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remain_q <= ZERO;
      else if (data_go)          remain_q <= reload;
      else if (remain_q != ZERO) remain_q <= remain_q - ONE;
   end
endmodule

// File: rtl/pacer_seq.sv
// Tracks an open access sequence: opened by a control write, closed once the
// spacing interval has drained after at least one data strobe.
module pacer_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic data_go,
   input  logic spacing_done,
   output logic seq_open
);
   logic open_q;
   logic data_seen_q;
   logic close_now;

   assign close_now = open_q && data_seen_q && spacing_done && !data_go;
   assign seq_open  = open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q      <= 1'b0;
         data_seen_q <= 1'b0;
      end else if (ctrl_wr) begin
         open_q      <= 1'b1;
         data_seen_q <= 1'b0;
      end else if (close_now) begin
         open_q      <= 1'b0;
         data_seen_q <= 1'b0;
      end else if (open_q && data_go) begin
         data_seen_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pacer_irq.sv
// Boot-complete flag and interrupt mask; IRQ_REG picks a combinational or
// registered interrupt output.
module pacer_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_wr,
   input  logic boot_val,
   input  logic seq_open,
   input  logic vid_irq,
   output logic cpu_irq
);
   logic booted_q;
   logic pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       booted_q <= 1'b0;
      else if (boot_wr) booted_q <= boot_val;
   end

   assign pass = vid_irq && booted_q && !seq_open;

   generate
      if (IRQ_REG) begin : g_reg_out
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pass;
         end
         assign cpu_irq = irq_q;
      end else begin : g_comb_out
         assign cpu_irq = pass;
      end
   endgenerate
endmodule

// File: rtl/io_pacer.sv
module io_pacer #(
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_interval,
   input  logic             io_req,
   input  logic [1:0]       io_port,
   input  logic             io_write,
   input  logic             io_wbit,
   output logic             cpu_wait,
   output logic             dev_data_stb,
   output logic             dev_ctrl_stb,
   input  logic             vid_irq,
   output logic             cpu_irq
);
   import io_pacer_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("io_pacer: CNT_W must lie in 2..16");
      end
   endgenerate

   port_sel_e sel;
   logic      data_req;
   logic      spacing_done;
   logic      data_go;
   logic      ctrl_wr;
   logic      boot_wr;
   logic      seq_open;

   assign sel      = port_sel_e'(io_port);
   assign data_req = io_req && (sel == PORT_DATA);
   assign data_go  = data_req && spacing_done;
   assign ctrl_wr  = io_req && io_write && (sel == PORT_CTRL);
   assign boot_wr  = io_req && io_write && (sel == PORT_BOOT);

   assign cpu_wait     = data_req && !spacing_done;
   assign dev_data_stb = data_go;
   assign dev_ctrl_stb = io_req && (sel == PORT_CTRL);

   pacer_interval #(.CNT_W(CNT_W)) u_interval (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_interval (cfg_interval),
      .data_go      (data_go),
      .spacing_done (spacing_done)
   );

   pacer_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr      (ctrl_wr),
      .data_go      (data_go),
      .spacing_done (spacing_done),
      .seq_open     (seq_open)
   );

   pacer_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_wr  (boot_wr),
      .boot_val (io_wbit),
      .seq_open (seq_open),
      .vid_irq  (vid_irq),
      .cpu_irq  (cpu_irq)
   );
endmodule

// File: rtl/io_pacer_chk.sv
module io_pacer_chk #(
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cfg_interval,
   input logic             io_req,
   input logic [1:0]       io_port,
   input logic             io_write,
   input logic             io_wbit,
   input logic             cpu_wait,
   input logic             dev_data_stb,
   input logic             dev_ctrl_stb,
   input logic             vid_irq,
   input logic             cpu_irq
);
   localparam logic [CNT_W:0] GAP_MAX = '1;

   logic [CNT_W:0] gap_q;
   logic           seen_q;
   logic           booted_q;
   logic           early;
   logic           irq_allowed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q    <= '0;
         seen_q   <= 1'b0;
         booted_q <= 1'b0;
      end else begin
         if (dev_data_stb) begin
            gap_q  <= {{CNT_W{1'b0}}, 1'b1};
            seen_q <= 1'b1;
         end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
         end
         if (io_req && io_write && io_port == 2'd2) booted_q <= io_wbit;
      end
   end

   assign early       = seen_q && (gap_q < {1'b0, cfg_interval});
   assign irq_allowed = vid_irq && booted_q;

   a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      dev_data_stb && seen_q |-> gap_q >= {1'b0, cfg_interval});

   a_r1_prompt_access: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && io_port == 2'd0 && !early |-> dev_data_stb && !cpu_wait);

   a_r3_stall_early: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && io_port == 2'd0 && early |-> cpu_wait && !dev_data_stb);

   a_r4_no_wait_other: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && io_port != 2'd0 |-> !cpu_wait);

   a_r6_seq_masks: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ctrl_stb && io_write |=> ##1 !cpu_irq);

   generate
      if (IRQ_REG) begin : g_chk_reg
         a_r5_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq |-> $past(irq_allowed));
      end else begin : g_chk_comb
         a_r5_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq |-> irq_allowed);
      end
   endgenerate
endmodule

bind io_pacer io_pacer_chk #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_interval (cfg_interval),
   .io_req       (io_req),
   .io_port      (io_port),
   .io_write     (io_write),
   .io_wbit      (io_wbit),
   .cpu_wait     (cpu_wait),
   .dev_data_stb (dev_data_stb),
   .dev_ctrl_stb (dev_ctrl_stb),
   .vid_irq      (vid_irq),
   .cpu_irq      (cpu_irq)
);

// File: tb/io_pacer_tb_top.sv
`timescale 1ns/1ps
module io_pacer_tb_top;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] cfg_interval = 8'd5;
   logic             io_req = 1'b0;
   logic [1:0]       io_port = 2'd0;
   logic             io_write = 1'b0;
   logic             io_wbit = 1'b0;
   logic             vid_irq = 1'b0;
   logic             cpu_wait, dev_data_stb, dev_ctrl_stb, cpu_irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   io_pacer #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
      .io_req(io_req), .io_port(io_port), .io_write(io_write), .io_wbit(io_wbit),
      .cpu_wait(cpu_wait), .dev_data_stb(dev_data_stb), .dev_ctrl_stb(dev_ctrl_stb),
      .vid_irq(vid_irq), .cpu_irq(cpu_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive at the falling edge, let combinational outputs settle
   task automatic drive(input logic req, input logic [1:0] port,
                        input logic wr, input logic wbit);
      @(negedge clk);
      io_req = req; io_port = port; io_write = wr; io_wbit = wbit;
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 1'b0, 1'b0);
   endtask

   task automatic t_reset();
      vid_irq = 1'b1;
      drive(1'b0, 2'd0, 1'b0, 1'b0);
      check("R5 reset cpu_irq", cpu_irq, 0);
      check("R1 reset cpu_wait", cpu_wait, 0);
      vid_irq = 1'b0;
   endtask

   // hold a data request for n accesses; verify gaps and wait
   task automatic t_burst(input int ival, input int n);
      int last, cyc, got;
      cfg_interval = ival[CNT_W-1:0];
      idle(ival + 2);
      last = -1; cyc = 0; got = 0;
      while (got < n && cyc < 2000) begin
         drive(1'b1, 2'd0, 1'b0, 1'b0);
         if (dev_data_stb) begin
            check("R3 no wait on strobe", cpu_wait, 0);
            if (last < 0) check("R1 first access immediate", cyc, 0);
            else check("R2 strobe gap", cyc - last, (ival < 1) ? 1 : ival);
            last = cyc; got++;
         end else begin
            check("R3 wait while early", cpu_wait, 1);
         end
         cyc++;
      end
      check("R3 all accesses done", got, n);
      idle(1);
   endtask

   task automatic t_other_ports();
      cfg_interval = 8'd10;
      idle(12);
      drive(1'b1, 2'd0, 1'b0, 1'b0);
      check("R1 strobe", dev_data_stb, 1);
      drive(1'b1, 2'd1, 1'b0, 1'b0);
      check("R4 ctrl no wait", cpu_wait, 0);
      check("R4 ctrl strobe", dev_ctrl_stb, 1);
      drive(1'b1, 2'd3, 1'b1, 1'b1);
      check("R9 other port no wait", cpu_wait, 0);
      drive(1'b1, 2'd2, 1'b0, 1'b0);
      check("R4 boot port no wait", cpu_wait, 0);
      idle(12);
   endtask

   task automatic t_boot();
      vid_irq = 1'b1;
      idle(2);
      check("R5 masked before boot", cpu_irq, 0);
      drive(1'b1, 2'd3, 1'b1, 1'b1);
      idle(1);
      check("R9 other port leaves flag", cpu_irq, 0);
      drive(1'b1, 2'd2, 1'b1, 1'b1);
      check("R5 not yet effective", cpu_irq, 0);
      idle(1);
      check("R5 boot set delivers", cpu_irq, 1);
      vid_irq = 1'b0; #1;
      check("R8 no irq without source", cpu_irq, 0);
      vid_irq = 1'b1; #1;
      drive(1'b1, 2'd2, 1'b1, 1'b0);
      idle(1);
      check("R5 boot cleared masks", cpu_irq, 0);
      drive(1'b1, 2'd2, 1'b1, 1'b1);
      idle(1);
      check("R5 boot set again", cpu_irq, 1);
      vid_irq = 1'b0;
   endtask

   task automatic t_sequence(input int ival);
      cfg_interval = ival[CNT_W-1:0];
      vid_irq = 1'b1;
      idle(ival + 2);
      check("R7 open before seq", cpu_irq, 1);
      drive(1'b1, 2'd1, 1'b1, 1'b0);
      idle(1);
      check("R6 ctrl write opens seq", cpu_irq, 0);
      idle(ival + 4);
      check("R6 stays open without data", cpu_irq, 0);
      drive(1'b1, 2'd3, 1'b1, 1'b0);
      idle(1);
      check("R9 other port no close", cpu_irq, 0);
      drive(1'b1, 2'd0, 1'b1, 1'b0);
      check("R1 seq data strobe", dev_data_stb, 1);
      // strobe taken at next edge; irq expected after ival more edges
      for (int k = 1; k <= ival; k++) begin
         drive(1'b0, 2'd0, 1'b0, 1'b0);
         check("R7 deferred until drained", cpu_irq, 0);
      end
      drive(1'b0, 2'd0, 1'b0, 1'b0);
      check("R7 delivered after drain", cpu_irq, 1);
      vid_irq = 1'b0;
   endtask

   initial begin
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_burst(5, 4);
      t_burst(1, 4);
      t_burst(0, 3);
      t_burst(12, 3);
      t_other_ports();
      t_boot();
      t_sequence(5);
      t_sequence(3);
      idle(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule